// File: doc/BRIEF.md
# Row-Stationary 2-D Convolution Array

This block computes one 2-D convolution pass of a small signed fixed-point filter over a strip of an input feature map. It uses a grid of processing elements (PEs). Each PE keeps one filter row in its own small register file for the whole pass. Each PE runs a 1-D sliding-window convolution of that row against one input row. The PEs that serve the same output row have their 1-D results summed into a single output value. With the default sizes, a 3-row by 3-tap filter and three output rows, the grid is 3 by 3 and needs five input rows.

A pass has four steps:

1. Software writes the filter taps one at a time through the weight port, addressed by row and tap.
2. The input rows are streamed in column by column. Every beat carries one pixel from each of the five input rows, and each row lane is written once into a shared row buffer. Every PE that needs that row reads it from there.
3. The array computes all outputs. A PE that sees a zero pixel skips its weight read and its multiply-accumulate for that step.
4. The results are scaled by a programmable arithmetic right shift, saturated to 16 bits, and sent out row by row over a valid/ready stream.

Top module: `rs_conv_array`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `out_valid` is 0 and `out_last` is 0.
- R2: A weight write stores `wl_data` as tap `wl_col` (0 = leftmost) of filter row `wl_row` (0 = top). Filter rows are held across passes, so a later pass without new writes uses the same taps.
- R3: With taps w[r][k] and input rows x[d][c] (d is the lane index inside `in_pix`, bits d*16 and up; c is the beat number), output row o, column j equals sat((Σr Σk w[r][k]·x[o+r][j+k]) >>> `frac_shift`). The sum runs over r in 0..2 and k in 0..2, o runs over 0..2 and j over 0..IMG_W-3.
- R4: Each pass emits exactly 3·(IMG_W−2) beats. Output row 0 comes first, then row 1, then row 2, each with j ascending. `out_last` is 1 only on the final beat.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` keep their values. No result is dropped or repeated.
- R6: A shifted sum above 32767 is output as 32767. A shifted sum below −32768 is output as −32768.
- R7: A zero pixel adds nothing to any sum. The PE's accumulator keeps its value on that step. An all-zero input gives all-zero outputs for any taps.
- R8: Weight writes take effect only while `in_ready` is 1 and no input beat of the current pass has been accepted. A write at any other time has no effect on this pass or on later passes.
- R9: `in_ready` falls right after the IMG_W-th input beat is accepted. It rises again in the cycle after the final output beat is accepted. `out_valid` is never 1 while `in_ready` is 1.
- R10: The shift in R3 is arithmetic, so negative sums round toward minus infinity (for example, −9 >>> 3 = −2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wl_valid | input | 1 | Weight write strobe |
| wl_row | input | 2 | Filter row of the written tap |
| wl_col | input | 2 | Tap position inside the row |
| wl_data | input | 16 | Signed tap value |
| frac_shift | input | 5 | Right-shift count applied before saturation; hold it steady for a whole pass |
| in_valid | input | 1 | Input column beat valid |
| in_ready | output | 1 | Array accepts an input column beat |
| in_pix | input | 80 | Five signed 16-bit pixels, lane d in bits d*16 and up |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 16 | Signed saturated output value |
| out_last | output | 1 | Marks the final beat of a pass |

## Verification
The bench uses several input patterns, each aimed at a different fault:
- A directed ramp image with small distinct taps exposes any swap of rows, taps or columns, because every product has its own weight.
- Random images in which most pixels are zero, with random shifts and a randomly toggled `out_ready`, exercise the zero-skip path together with backpressure. A skipped step that corrupts the accumulator, or a stall that loses or repeats a beat, shows up as a mismatch.
- Full-scale positive and negative images separate saturation from wraparound.
- Small negative sums with a nonzero shift separate arithmetic shifting from logical shifting.
- An all-zero image under large taps checks that zero pixels contribute nothing.
- A weight write issued during computation, followed by a pass with no reload, shows whether taps stay resident and whether late writes are locked out.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

  // Pass phases: collect input columns, issue compute steps, wait for the
  // pipeline to retire, stream results out.
  typedef enum logic [1:0] {
    PH_FILL  = 2'd0,
    PH_CALC  = 2'd1,
    PH_DRAIN = 2'd2,
    PH_SEND  = 2'd3
  } phase_t;

  // Index width that never collapses to zero bits.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rsa_rowbuf.sv
// One input-row store, shared by every PE on its diagonal.
// Synchronous write and registered read, so block RAM can be inferred.
module rsa_rowbuf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int AW     = 3
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic signed [DATA_W-1:0] wdata,
  input  logic [AW-1:0]            raddr,
  output logic signed [DATA_W-1:0] rdata
);

  logic signed [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rsa_pe.sv
// Processing element: one filter row resident in a tiny register file,
// one multiply-accumulate per step, and the step is skipped for zero pixels.
module rsa_pe #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int TAPS   = 3,
  parameter int TAP_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wl_en,
  input  logic [TAP_W-1:0]         wl_tap,
  input  logic signed [DATA_W-1:0] wl_data,
  input  logic                     step_en,
  input  logic [TAP_W-1:0]         step_tap,
  input  logic                     step_first,
  input  logic signed [DATA_W-1:0] pix,
  output logic signed [ACC_W-1:0]  acc
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] wrf [TAPS];
  logic                     nz;
  logic signed [DATA_W-1:0] wsel;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;

  always_ff @(posedge clk) begin
    if (wl_en) wrf[wl_tap] <= wl_data;
  end

  assign nz = (pix != '0);

  // The register file is only read when the pixel is nonzero.
  always_comb begin
    wsel = '0;
    if (nz) wsel = wrf[step_tap];
  end

  assign prod     = wsel * pix;
  assign prod_ext = ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (step_en) begin
      if (step_first)  acc <= nz ? prod_ext : '0;
      else if (nz)     acc <= acc + prod_ext;
    end
  end

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step_en && !step_first && pix == '0) |=> $stable(acc)); // R7

endmodule

// File: rtl/rsa_combine.sv
// Adds the row partial sums of one output row, scales and saturates.
module rsa_combine #(
  parameter int DATA_W  = 16,
  parameter int ACC_W   = 40,
  parameter int N       = 3,
  parameter int SHIFT_W = 5
) (
  input  logic [N*ACC_W-1:0]       psums,
  input  logic [SHIFT_W-1:0]       shift,
  output logic signed [DATA_W-1:0] result
);

  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] shifted;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) begin
      sum = sum + $signed(psums[i*ACC_W +: ACC_W]);
    end
    shifted = sum >>> shift;
    if (shifted > MAXV)      result = MAXV[DATA_W-1:0];
    else if (shifted < MINV) result = MINV[DATA_W-1:0];
    else                     result = shifted[DATA_W-1:0];
  end

endmodule

// File: rtl/rs_conv_array.sv
module rs_conv_array import rsa_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 40,
  parameter int F_ROWS   = 3,
  parameter int F_COLS   = 3,
  parameter int OUT_ROWS = 3,
  parameter int IMG_W    = 8,
  parameter int SHIFT_W  = 5,
  localparam int NDIAG   = OUT_ROWS + F_ROWS - 1,
  localparam int RW      = idx_w(F_ROWS),
  localparam int KW      = idx_w(F_COLS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wl_valid,
  input  logic [RW-1:0]           wl_row,
  input  logic [KW-1:0]           wl_col,
  input  logic [DATA_W-1:0]       wl_data,
  input  logic [SHIFT_W-1:0]      frac_shift,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NDIAG*DATA_W-1:0] in_pix,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic                    out_last
);

  localparam int NOUT  = IMG_W - F_COLS + 1;
  localparam int COL_W = idx_w(IMG_W);
  localparam int JW    = idx_w(NOUT);
  localparam int OW    = idx_w(OUT_ROWS);

  phase_t           ph;
  logic [COL_W-1:0] in_col;
  logic             in_fire;
  logic             wl_ok;

  logic [JW-1:0]    cj;
  logic [KW-1:0]    ck;
  logic             issue;
  logic [COL_W-1:0] rd_addr;

  logic             s1_vld, s1_first, s1_last;
  logic [KW-1:0]    s1_tap;
  logic [JW-1:0]    s1_j;
  logic             s2_vld;
  logic [JW-1:0]    s2_j;

  logic [OW-1:0]    e_row;
  logic [JW-1:0]    e_col;
  logic             send_done;
  logic             send_go;
  logic             e_end;

  logic signed [DATA_W-1:0] diag_pix [NDIAG];
  logic signed [DATA_W-1:0] row_rd   [OUT_ROWS];

  assign in_ready = (ph == PH_FILL);
  assign in_fire  = in_valid && in_ready;
  assign wl_ok    = wl_valid && (ph == PH_FILL) && (in_col == '0);
  assign issue    = (ph == PH_CALC);
  assign rd_addr  = COL_W'(cj) + COL_W'(ck);
  assign send_go  = (ph == PH_SEND) && !send_done && (!out_valid || out_ready);
  assign e_end    = (e_row == OW'(OUT_ROWS - 1)) && (e_col == JW'(NOUT - 1));

  // Input row stores, one per diagonal lane, each written once per pass.
  for (genvar d = 0; d < NDIAG; d++) begin : g_row
    rsa_rowbuf #(.DATA_W(DATA_W), .DEPTH(IMG_W), .AW(COL_W)) u_rb (
      .clk   (clk),
      .we    (in_fire),
      .waddr (in_col),
      .wdata (in_pix[d*DATA_W +: DATA_W]),
      .raddr (rd_addr),
      .rdata (diag_pix[d])
    );
  end

  // PE grid: output row o, filter row r reads diagonal o+r.
  for (genvar o = 0; o < OUT_ROWS; o++) begin : g_out
    logic [F_ROWS*ACC_W-1:0]  psums;
    logic signed [DATA_W-1:0] res;
    logic signed [DATA_W-1:0] obuf [NOUT];

    for (genvar r = 0; r < F_ROWS; r++) begin : g_pe
      logic signed [ACC_W-1:0] acc;
      rsa_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W), .TAPS(F_COLS), .TAP_W(KW)) u_pe (
        .clk        (clk),
        .rst        (rst),
        .wl_en      (wl_ok && (wl_row == RW'(r))),
        .wl_tap     (wl_col),
        .wl_data    (wl_data),
        .step_en    (s1_vld),
        .step_tap   (s1_tap),
        .step_first (s1_first),
        .pix        (diag_pix[o + r]),
        .acc        (acc)
      );
      assign psums[r*ACC_W +: ACC_W] = acc;
    end

    rsa_combine #(.DATA_W(DATA_W), .ACC_W(ACC_W), .N(F_ROWS), .SHIFT_W(SHIFT_W)) u_comb (
      .psums  (psums),
      .shift  (frac_shift),
      .result (res)
    );

    always_ff @(posedge clk) begin
      if (s2_vld) obuf[s2_j] <= res;
    end

    assign row_rd[o] = obuf[e_col];
  end

  // Compute pipeline tags: issue -> row read -> PE step -> result write.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_tap   <= '0;
      s1_j     <= '0;
      s2_vld   <= 1'b0;
      s2_j     <= '0;
    end else begin
      s1_vld   <= issue;
      s1_first <= (ck == '0);
      s1_last  <= (ck == KW'(F_COLS - 1));
      s1_tap   <= ck;
      s1_j     <= cj;
      s2_vld   <= s1_vld && s1_last;
      s2_j     <= s1_j;
    end
  end

  // Pass control and output stream.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_FILL;
      in_col    <= '0;
      cj        <= '0;
      ck        <= '0;
      e_row     <= '0;
      e_col     <= '0;
      send_done <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      case (ph)
        PH_FILL: begin
          if (in_fire) begin
            if (in_col == COL_W'(IMG_W - 1)) begin
              in_col <= '0;
              cj     <= '0;
              ck     <= '0;
              ph     <= PH_CALC;
            end else begin
              in_col <= in_col + 1'b1;
            end
          end
        end
        PH_CALC: begin
          if (ck == KW'(F_COLS - 1)) begin
            ck <= '0;
            if (cj == JW'(NOUT - 1)) ph <= PH_DRAIN;
            else                     cj <= cj + 1'b1;
          end else begin
            ck <= ck + 1'b1;
          end
        end
        PH_DRAIN: begin
          if (s2_vld && s2_j == JW'(NOUT - 1)) begin
            e_row     <= '0;
            e_col     <= '0;
            send_done <= 1'b0;
            ph        <= PH_SEND;
          end
        end
        default: begin
          if (send_go) begin
            out_valid <= 1'b1;
            out_data  <= row_rd[e_row];
            out_last  <= e_end;
            if (e_end) begin
              send_done <= 1'b1;
            end else if (e_col == JW'(NOUT - 1)) begin
              e_col <= '0;
              e_row <= e_row + 1'b1;
            end else begin
              e_col <= e_col + 1'b1;
            end
          end else if (out_valid && out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            if (out_last) begin
              send_done <= 1'b0;
              ph        <= PH_FILL;
            end
          end
        end
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R5

  AST_FILL_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (in_fire && in_col == COL_W'(IMG_W - 1)) |=> !in_ready); // R9

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid); // R9

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (!out_valid && in_ready)); // R4

endmodule

// File: tb/rs_conv_array_test.sv
`timescale 1ns/1ps
module rs_conv_array_test;

  localparam int DW    = 16;
  localparam int FR    = 3;
  localparam int FC    = 3;
  localparam int OR    = 3;
  localparam int IW    = 8;
  localparam int ND    = OR + FR - 1;
  localparam int NO    = IW - FC + 1;
  localparam int TOTAL = OR * NO;

  logic            clk = 1'b0;
  logic            rst;
  logic            wl_valid;
  logic [1:0]      wl_row;
  logic [1:0]      wl_col;
  logic [DW-1:0]   wl_data;
  logic [4:0]      frac_shift;
  logic            in_valid;
  logic            in_ready;
  logic [ND*DW-1:0] in_pix;
  logic            out_valid;
  logic            out_ready;
  logic [DW-1:0]   out_data;
  logic            out_last;

  int total = 0;
  int bad   = 0;
  int wgt [FR][FC];
  int img [ND][IW];

  always #5 clk = ~clk;

  rs_conv_array uut (
    .clk(clk), .rst(rst), .wl_valid(wl_valid), .wl_row(wl_row), .wl_col(wl_col),
    .wl_data(wl_data), .frac_shift(frac_shift), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  function automatic int model(input int o, input int j, input int sh);
    longint s = 0;
    for (int r = 0; r < FR; r++)
      for (int k = 0; k < FC; k++)
        s += longint'(wgt[r][k]) * longint'(img[o + r][j + k]);
    s = s >>> sh;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic load_weights();
    for (int r = 0; r < FR; r++)
      for (int k = 0; k < FC; k++) begin
        @(negedge clk);
        wl_valid = 1'b1;
        wl_row   = 2'(r);
        wl_col   = 2'(k);
        wl_data  = DW'(wgt[r][k]);
      end
    @(negedge clk);
    wl_valid = 1'b0;
  endtask

  // One full pass: stream columns, optionally attempt a late weight write,
  // collect and check every output beat.
  task automatic run_pass(input int sh, input int rdy_pct, input string tag, input bit late_wl);
    int  idx;
    bit  held;
    logic [DW-1:0] held_data;
    frac_shift = 5'(sh);
    for (int c = 0; c < IW; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int d = 0; d < ND; d++) in_pix[d*DW +: DW] = DW'(img[d][c]);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R9 in_ready low after last beat", in_ready, 0);
    if (late_wl) begin
      for (int i = 0; i < 4; i++) begin
        wl_valid = 1'b1;
        wl_row   = 2'(i % FR);
        wl_col   = 2'(i % FC);
        wl_data  = 16'h1234;
        @(negedge clk);
      end
      wl_valid = 1'b0;
    end
    idx  = 0;
    held = 1'b0;
    held_data = '0;
    while (idx < TOTAL) begin
      if (held) begin
        chk(out_valid == 1'b1 && out_data == held_data, "R5 stalled beat held",
            out_data, held_data);
      end
      out_ready = (($urandom % 100) < rdy_pct);
      if (out_valid) begin
        chk(in_ready == 1'b0, "R9 no input while output pending", in_ready, 0);
        if (out_ready) begin
          chk($signed(out_data) == model(idx / NO, idx % NO, sh), tag,
              $signed(out_data), model(idx / NO, idx % NO, sh));
          chk(out_last == (idx == TOTAL - 1), "R4 last flag position", out_last,
              (idx == TOTAL - 1));
          idx++;
          held = 1'b0;
        end else begin
          held = 1'b1;
          held_data = out_data;
        end
      end else begin
        held = 1'b0;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R4 no extra beat, R9 ready again",
        {out_valid, in_ready}, 1);
  endtask

  function automatic int rnd_pix(input int zero_pct, input int mag);
    if (($urandom % 100) < zero_pct) return 0;
    return int'($urandom % (2 * mag + 1)) - mag;
  endfunction

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wl_valid = 1'b0; wl_row = '0; wl_col = '0; wl_data = '0;
    frac_shift = '0; in_valid = 1'b0; in_pix = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0 && out_last == 1'b0, "R1 outputs idle after reset",
        {out_valid, out_last}, 0);

    // Directed: distinct taps, ramp image with some zeros.
    for (int r = 0; r < FR; r++) for (int k = 0; k < FC; k++) wgt[r][k] = r * FC + k + 1;
    for (int d = 0; d < ND; d++) for (int c = 0; c < IW; c++)
      img[d][c] = ((d + c) % 4 == 0) ? 0 : (d * 10 + c - 7);
    load_weights();
    run_pass(0, 100, "R3 directed ramp", 1'b0);

    // Late weight write while busy must be ignored (R8), taps persist (R2).
    for (int d = 0; d < ND; d++) for (int c = 0; c < IW; c++) img[d][c] = rnd_pix(50, 200);
    run_pass(1, 70, "R8 late write ignored", 1'b1);
    for (int d = 0; d < ND; d++) for (int c = 0; c < IW; c++) img[d][c] = rnd_pix(30, 500);
    run_pass(2, 100, "R2 taps kept across passes", 1'b0);

    // Random sparse images with backpressure.
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < FR; r++) for (int k = 0; k < FC; k++)
        wgt[r][k] = int'($urandom % 4001) - 2000;
      for (int d = 0; d < ND; d++) for (int c = 0; c < IW; c++) img[d][c] = rnd_pix(65, 3000);
      load_weights();
      run_pass(int'($urandom % 11), 50, "R3 R7 random sparse", 1'b0);
    end

    // Saturation, both directions.
    for (int r = 0; r < FR; r++) for (int k = 0; k < FC; k++) wgt[r][k] = 32767;
    load_weights();
    for (int d = 0; d < ND; d++) for (int c = 0; c < IW; c++) img[d][c] = 32767;
    run_pass(0, 100, "R6 positive saturation", 1'b0);
    for (int d = 0; d < ND; d++) for (int c = 0; c < IW; c++) img[d][c] = -32768;
    run_pass(0, 60, "R6 negative saturation", 1'b0);

    // All-zero image under full-scale taps.
    for (int d = 0; d < ND; d++) for (int c = 0; c < IW; c++) img[d][c] = 0;
    run_pass(0, 100, "R7 zero image", 1'b0);

    // Arithmetic shift on small negative sums: centre tap -1 only.
    for (int r = 0; r < FR; r++) for (int k = 0; k < FC; k++) wgt[r][k] = 0;
    wgt[1][1] = -1;
    load_weights();
    for (int d = 0; d < ND; d++) for (int c = 0; c < IW; c++) img[d][c] = 2 * c + d + 3;
    run_pass(3, 100, "R10 floor shift", 1'b0);

    summary();
    $finish;
  end

endmodule